// File: doc/BRIEF.md
# Dual Down-Counting Timer

This peripheral holds two identical timer channels behind a small register bus that carries an address, a write strobe, write data and combinational read data. Each channel has a 24-bit counter that counts down from a value software loads. A prescaler slows the count by 1, 16 or 256. When the count steps from one to zero, the channel sets an interrupt flag. In periodic mode the channel then reloads itself. In one-shot mode it stops at zero.

Channel 0's flag drives the interrupt output. Channel 1 is normally loaded with the largest value and left running in periodic mode, so software can use it as a time base. Inverting its count gives the number of prescaled ticks elapsed. Software programs a channel in two steps: it writes the load value, then writes the control word.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every readable register of both channels reads zero and `irq_o` is low.
- R2: Address bit 5 selects the channel. Bits 3:2 select the register: 0 is load, 1 is current count, 2 is control, 3 is interrupt clear. Addresses with bit 4 set read zero and ignore writes.
- R3: A write to the load register stores bits 23:0 of the data as both the load value and the current count. Bits 31:24 are dropped, and both registers read them back as zero.
- R4: The control register keeps the enable flag in bit 7, the periodic flag in bit 6 and the divider code in bits 3:2. Every other bit reads zero. The interrupt-clear register always reads zero.
- R5: Divider code 0 gives a tick every cycle, code 1 every 16th cycle, and codes 2 and 3 every 256th cycle. A control write restarts the divider and gives no tick in its own cycle. Ticks then come every N cycles counted from that write.
- R6: On each tick of an enabled channel, a nonzero count drops by one. A disabled channel holds its count.
- R7: In one-shot mode (bit 6 clear), a count of zero stays at zero on later ticks.
- R8: In periodic mode, a tick at count zero reloads the stored load value and does not set the flag.
- R9: A tick that takes the count from 1 to 0 sets the channel's flag. The flag stays set until it is cleared. `irq_o` follows channel 0's flag.
- R10: Any write to a channel's interrupt-clear register clears its flag. If a 1-to-0 tick happens in the same cycle, the flag stays set.
- R11: A load write in the same cycle as a tick wins: the count takes the written value.
- R12: The two channels are independent. Channel 1 can run periodic from 0xFFFFFF as a time base whose inverted count equals the ticks elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt, channel 0 flag |

## Verification
Directed sequences separate the main behaviours, each with expected values worked out by hand:
- a one-shot countdown from 3, which fires on the third tick and then rests at zero;
- a periodic countdown from 2, where a clear lands on the firing tick (the event must win) and the next tick reloads without firing;
- a divide-by-16 run on channel 1, which must not move for 15 cycles and then drop by one;
- a load written during a tick, and writes to the unmapped hole.

A random phase then mixes load, control and clear writes with small load values and all divider codes across both channels. In every cycle it compares the interrupt and one random register read against a behavioural model. This exposes ordering faults between reload, decrement, clear and divider restart that the directed cases only touch once.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int CNT_W   = 24;
    localparam int DATA_W  = 32;
    localparam int PRE_W   = 8;
    localparam int CH_LSB  = 5;

    // register index taken from address bits 4:2
    localparam logic [2:0] REG_LOAD  = 3'd0;
    localparam logic [2:0] REG_COUNT = 3'd1;
    localparam logic [2:0] REG_CTRL  = 3'd2;
    localparam logic [2:0] REG_CLR   = 3'd3;

    localparam int EN_BIT  = 7;
    localparam int PER_BIT = 6;
    localparam int DIV_LSB = 2;

    localparam logic [1:0] DIV_BY1  = 2'd0;
    localparam logic [1:0] DIV_BY16 = 2'd1;

    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] count;
        logic             en;
        logic             per;
        logic [1:0]       div;
        logic             flag;
    } chan_state_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] div_i,
    input  logic       restart_i,
    output logic       tick_o
);

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        case (div_i)
            DIV_BY1:  limit = '0;
            DIV_BY16: limit = PRE_W'(15);
            default:  limit = '1;
        endcase
        tick_o = en_i && !restart_i && (cnt_q == limit);
        if (restart_i || !en_i)
            cnt_d = '0;
        else if (cnt_q == limit)
            cnt_d = '0;
        else
            cnt_d = cnt_q + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != DIV_BY1 && !restart_i) |=> !tick_o);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic             ctl_we,
    input  logic             clr_we,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             ctl_en,
    input  logic             ctl_per,
    input  logic [1:0]       ctl_div,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] count_o,
    output logic             en_o,
    output logic             per_o,
    output logic [1:0]       div_o,
    output logic             flag_o
);

    chan_state_t st_d, st_q;
    logic        tick;
    logic        zero_evt;

    tmr_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (st_q.en),
        .div_i     (st_q.div),
        .restart_i (ctl_we),
        .tick_o    (tick)
    );

    always_comb begin
        st_d     = st_q;
        zero_evt = !ld_we && tick && (st_q.count == CNT_W'(1));
        if (ld_we) begin
            st_d.load  = ld_val;
            st_d.count = ld_val;
        end else if (tick) begin
            if (st_q.count != '0)
                st_d.count = st_q.count - CNT_W'(1);
            else if (st_q.per)
                st_d.count = st_q.load;
        end
        if (ctl_we) begin
            st_d.en  = ctl_en;
            st_d.per = ctl_per;
            st_d.div = ctl_div;
        end
        st_d.flag = zero_evt || (st_q.flag && !clr_we);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o  = st_q.load;
    assign count_o = st_q.count;
    assign en_o    = st_q.en;
    assign per_o   = st_q.per;
    assign div_o   = st_q.div;
    assign flag_o  = st_q.flag;

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> (st_q.count == $past(ld_val)) && (st_q.load == $past(ld_val)));

    // R6
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !ld_we) |=> $stable(st_q.count));

    // R7
    oneshot_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.per && st_q.count == '0 && !ld_we) |=> st_q.count == '0);

    // R9
    flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(st_q.count) == CNT_W'(1));

    // R10
    flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(clr_we));

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import timer_pkg::*;
#(
    parameter int N_CH = 2,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int ADDR_W = CH_LSB + CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    logic [CH_W-1:0]  ch_sel;
    logic [2:0]       reg_sel;
    logic [CNT_W-1:0] ch_load  [N_CH];
    logic [CNT_W-1:0] ch_count [N_CH];
    logic             ch_en    [N_CH];
    logic             ch_per   [N_CH];
    logic [1:0]       ch_div   [N_CH];
    logic             ch_flag  [N_CH];
    logic             unused_bits;

    assign ch_sel      = bus_addr[CH_LSB +: CH_W];
    assign reg_sel     = bus_addr[4:2];
    assign unused_bits = ^{bus_wdata[DATA_W-1:CNT_W], bus_addr[1:0]};

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic hit;
        assign hit = bus_we && (ch_sel == CH_W'(c));

        tmr_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_we   (hit && reg_sel == REG_LOAD),
            .ctl_we  (hit && reg_sel == REG_CTRL),
            .clr_we  (hit && reg_sel == REG_CLR),
            .ld_val  (bus_wdata[CNT_W-1:0]),
            .ctl_en  (bus_wdata[EN_BIT]),
            .ctl_per (bus_wdata[PER_BIT]),
            .ctl_div (bus_wdata[DIV_LSB +: 2]),
            .load_o  (ch_load[c]),
            .count_o (ch_count[c]),
            .en_o    (ch_en[c]),
            .per_o   (ch_per[c]),
            .div_o   (ch_div[c]),
            .flag_o  (ch_flag[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (ch_sel == CH_W'(c)) begin
                case (reg_sel)
                    REG_LOAD:  bus_rdata[CNT_W-1:0] = ch_load[c];
                    REG_COUNT: bus_rdata[CNT_W-1:0] = ch_count[c];
                    REG_CTRL: begin
                        bus_rdata[EN_BIT]       = ch_en[c];
                        bus_rdata[PER_BIT]      = ch_per[c];
                        bus_rdata[DIV_LSB +: 2] = ch_div[c];
                    end
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

    assign irq_o = ch_flag[0];

    // R2
    hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[4] |-> bus_rdata == '0);

    // R4
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == REG_CTRL) |-> (bus_rdata & ~DATA_W'(32'h0000_00CC)) == '0);

endmodule

// File: tb/dual_down_timer_bench.sv
module dual_down_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural model, one entry per channel
    logic [23:0] m_load  [2];
    logic [23:0] m_count [2];
    logic        m_en    [2];
    logic        m_per   [2];
    logic [1:0]  m_div   [2];
    logic        m_flag  [2];
    int          m_pre   [2];

    dual_down_timer u_dual_down_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_load[c] = '0; m_count[c] = '0; m_en[c] = 0; m_per[c] = 0;
            m_div[c] = '0; m_flag[c] = 0; m_pre[c] = 0;
        end
    endtask

    task automatic model_step(input logic we, input logic [5:0] a, input logic [31:0] d);
        for (int c = 0; c < 2; c++) begin
            logic sel, ld, ctl, clr, tick, evt;
            int lim;
            sel  = we && (a[5] == c[0]) && !a[4];
            ld   = sel && a[3:2] == 2'd0;
            ctl  = sel && a[3:2] == 2'd2;
            clr  = sel && a[3:2] == 2'd3;
            lim  = (m_div[c] == 2'd0) ? 0 : (m_div[c] == 2'd1) ? 15 : 255;
            tick = m_en[c] && !ctl && (m_pre[c] == lim);
            evt  = !ld && tick && (m_count[c] == 24'd1);
            if (ctl || !m_en[c] || m_pre[c] == lim) m_pre[c] = 0;
            else m_pre[c] = m_pre[c] + 1;
            if (ld) begin
                m_load[c]  = d[23:0];
                m_count[c] = d[23:0];
            end else if (tick) begin
                if (m_count[c] != 0) m_count[c] = m_count[c] - 24'd1;
                else if (m_per[c])   m_count[c] = m_load[c];
            end
            if (ctl) begin
                m_en[c] = d[7]; m_per[c] = d[6]; m_div[c] = d[3:2];
            end
            m_flag[c] = evt || (m_flag[c] && !clr);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [5:0] a);
        int c;
        c = a[5] ? 1 : 0;
        if (a[4]) return '0;
        case (a[3:2])
            2'd0:    return {8'h0, m_load[c]};
            2'd1:    return {8'h0, m_count[c]};
            2'd2:    return {24'h0, m_en[c], m_per[c], 2'b00, m_div[c], 2'b00};
            default: return '0;
        endcase
    endfunction

    // called at a negedge; returns at the next negedge
    task automatic do_cycle(input logic we, input logic [5:0] a, input logic [31:0] d, input string req);
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step(we, a, d);
        @(negedge clk);
        bus_we = 0;
        chk(req, {31'b0, irq_o}, {31'b0, m_flag[0]});
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) do_cycle(0, 6'h00, 32'h0, req);
    endtask

    task automatic rd_chk(input logic [5:0] a, input string req);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, m_read(a));
    endtask

    task automatic rd_lit(input logic [5:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        for (int a = 0; a < 64; a += 4) rd_lit(6'(a), 32'h0, "R1 reset read");

        // R3 load masking
        do_cycle(1, 6'h00, 32'hAB12_3456, "R3");
        rd_lit(6'h00, 32'h0012_3456, "R3 load");
        rd_lit(6'h04, 32'h0012_3456, "R3 count");

        // R4 control readback
        do_cycle(1, 6'h28, 32'hFFFF_FF33, "R4");
        rd_lit(6'h28, 32'h0000_0000, "R4 masked bits");
        do_cycle(1, 6'h28, 32'hFFFF_FFFF, "R4");
        rd_lit(6'h28, 32'h0000_00CC, "R4 ctrl all");
        rd_lit(6'h2C, 32'h0, "R4 clr reads zero");
        do_cycle(1, 6'h28, 32'h0, "R4");

        // R7 R9 one-shot from 3
        do_cycle(1, 6'h00, 32'd3, "R9");
        do_cycle(1, 6'h08, 32'h80, "R9");
        idle(2, "R9");
        chk("R9 no early irq", {31'b0, irq_o}, 32'h0);
        idle(1, "R9");
        chk("R9 irq at zero", {31'b0, irq_o}, 32'h1);
        idle(3, "R7");
        rd_lit(6'h04, 32'h0, "R7 rests at zero");
        chk("R9 flag held", {31'b0, irq_o}, 32'h1);

        // R10 clear, then clear colliding with an event
        do_cycle(1, 6'h0C, 32'h1234, "R10");
        chk("R10 cleared", {31'b0, irq_o}, 32'h0);
        do_cycle(1, 6'h00, 32'd2, "R10");
        do_cycle(1, 6'h08, 32'hC0, "R10");
        idle(1, "R10");
        do_cycle(1, 6'h0C, 32'h0, "R10");
        chk("R10 event beats clear", {31'b0, irq_o}, 32'h1);
        do_cycle(1, 6'h0C, 32'h0, "R8");
        chk("R8 reload no event", {31'b0, irq_o}, 32'h0);
        rd_lit(6'h04, 32'd2, "R8 reloaded");

        // R11 load during tick
        do_cycle(1, 6'h00, 32'd9, "R11");
        rd_lit(6'h04, 32'd9, "R11 load wins");

        // R6 disabled holds
        do_cycle(1, 6'h08, 32'h0, "R6");
        idle(5, "R6");
        rd_lit(6'h04, 32'd9, "R6 hold");

        // R2 hole ignored
        do_cycle(1, 6'h10, 32'hFFFF_FFFF, "R2");
        do_cycle(1, 6'h30, 32'hFFFF_FFFF, "R2");
        do_cycle(1, 6'h38, 32'hFFFF_FFFF, "R2");
        rd_lit(6'h10, 32'h0, "R2 hole read");
        rd_lit(6'h00, 32'd9, "R2 load untouched");
        rd_lit(6'h28, 32'h0, "R2 ctrl untouched");

        // R5 R12 divide by 16 on channel 1 as time base
        do_cycle(1, 6'h20, 32'h00FF_FFFF, "R12");
        do_cycle(1, 6'h28, 32'hC4, "R5");
        idle(15, "R5");
        rd_lit(6'h24, 32'h00FF_FFFF, "R5 no tick before 16");
        idle(1, "R5");
        rd_lit(6'h24, 32'h00FF_FFFE, "R5 tick at 16");
        bus_addr = 6'h24; #1;
        chk("R12 inverted count", {8'h0, ~bus_rdata[23:0]}, 32'd1);

        // random phase: R6 R7 R8 R9 R10 R11 R5 R12
        for (int i = 0; i < N_RAND; i++) begin
            logic [5:0]  a;
            logic [31:0] d;
            logic        we;
            int          r;
            we = ($urandom_range(0, 9) < 2);
            a  = {1'($urandom), 1'b0, 2'($urandom), 2'($urandom)};
            if ($urandom_range(0, 19) == 0) a[4] = 1'b1;
            r  = a[3:2];
            d  = $urandom;
            if (r == 0) d = ($urandom_range(0, 15) == 0) ? $urandom : 32'($urandom_range(0, 12));
            if (r == 2) begin
                d[7] = ($urandom_range(0, 4) != 0);
                d[3:2] = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'd0;
            end
            do_cycle(we, a, d, "R6 R8 R10 R11 random");
            rd_chk({1'($urandom), 1'b0, 2'($urandom), 2'b00}, "R7 R9 R5 random read");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule